// File: doc/BRIEF.md
# Dual-Channel Reload Down-Counter Timer

This peripheral gives a small processor two independent 16-bit down-counters. Each channel has a count register and a reload register. While its count enable is set, a channel decrements once per pulse on the `tick` input. The tick comes from an external prescaler, so the block never counts raw clocks. When a channel's count steps down to zero it raises its interrupt flag. On the following tick it reloads from the reload register and keeps counting.

Software reaches the block through a byte-wide register port with a combinational read path and single-cycle writes. A shared control/status byte holds the two flags, two interrupt enables, two count enables and a two-bit output mode for channel 1. The interrupt request is the OR of each flag gated by its enable. A flag is cleared only by a short read protocol: first read the status byte, then read either byte of that channel's count. Channel 1 can also drive the `tmr_out` pin when an external select input allows it. At each channel 1 terminal count the pin toggles, goes low, goes high or stays as it is, according to the mode field.

Top module: `dual_reload_timer`

## Requirements
- R1: A channel's flag becomes 1 on the clock edge at which a tick moves its count from 1 to 0.
- R2: A flag clears only when a count-byte read of that channel (ch0: address 4 or 5, ch1: address 8 or 9) follows a status read (address 0) with no count-byte read of that channel in between. A count-byte read on its own leaves the flag set.
- R3: `irq` is 1 exactly when, for some channel, both the flag and the interrupt enable are 1.
- R4: The status byte at address 0 reads {flag1, flag0, ie1, ie0, mode[1:0], en1, en0}, from bit 7 down to bit 0. Writes update bits 5..0 only.
- R5: At a channel 1 terminal count with `out_sel`=1, mode 01 toggles `tmr_out`, mode 10 drives it to 0, mode 11 drives it to 1, and mode 00 leaves it unchanged.
- R6: With `out_sel`=0, `tmr_out` does not change.
- R7: While a channel's enable is 0 its count holds. Its count bytes (low at the lower address) and reload bytes (ch0: 6/7, ch1: 10/11) can be written and read back at any time. A count write takes precedence over a tick in the same cycle.
- R8: Reset clears both counts and reloads, the flags, enables, mode bits and `tmr_out`. All reads then return 0.
- R9: An enabled channel whose count is 0 loads its reload value on the next tick and sets no flag on that tick.
- R10: An enabled channel's count changes only in cycles where `tick` is 1.
- R11: If a flag is set in the same cycle that the clear sequence completes, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count pulse from the external prescaler |
| out_sel | input | 1 | 1 lets channel 1 drive `tmr_out` |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (drives the flag-clear protocol) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Channel 1 timer output pin |

## Verification
Several rules are checked by bound properties on every cycle:
- `irq` agrees with the flag and enable bits seen in any status read.
- A flag rises after a tick takes its count from 1 to 0.
- A flag can only fall right after a count-byte read.
- A disabled count does not move unless it is written.
- `tmr_out` cannot change while `out_sel` is low.

Other rules depend on history and only the bench's scenarios can show them:
- the two-step clear and its arming state;
- the reload on the tick after zero;
- the four output modes in sequence;
- set-over-clear priority when both land in one cycle.

The bench's reference model is compared on every cycle to cover these.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int STAT_ADDR = 0;
  localparam int CH_BASE0  = 4;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'b00,
    OUT_TOGGLE = 2'b01,
    OUT_LOW    = 2'b10,
    OUT_HIGH   = 2'b11
  } out_mode_e;

  // Each channel occupies 2*nb bytes: count bytes, then reload bytes.
  function automatic int ch_base(input int ch, input int nb);
    return CH_BASE0 + ch * 2 * nb;
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int BASE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              count_en,
  input  logic              stat_rd,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  rld_q,
  output logic              flag_q,
  output logic              term_ev
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_d, rld_d;
  logic             flag_d, arm_q, arm_d;
  logic             cnt_wr, cnt_rd;

  always_comb begin
    cnt_d   = cnt_q;
    rld_d   = rld_q;
    cnt_wr  = 1'b0;
    cnt_rd  = 1'b0;
    term_ev = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (addr == ADDR_W'(BASE + b)) begin
        if (wr_en) begin
          cnt_d[8*b +: 8] = wdata;
          cnt_wr          = 1'b1;
        end
        if (rd_en) cnt_rd = 1'b1;
      end
      if (wr_en && addr == ADDR_W'(BASE + NB + b)) rld_d[8*b +: 8] = wdata;
    end
    if (!cnt_wr && tick && count_en) begin
      if (cnt_q == '0) begin
        cnt_d = rld_q;
      end else begin
        cnt_d   = cnt_q - CNT_W'(1);
        term_ev = (cnt_q == CNT_W'(1));
      end
    end
    // a fresh terminal count outranks a completing clear sequence
    if (term_ev)              flag_d = 1'b1;
    else if (arm_q && cnt_rd) flag_d = 1'b0;
    else                      flag_d = flag_q;
    if (stat_rd)     arm_d = 1'b1;
    else if (cnt_rd) arm_d = 1'b0;
    else             arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl
  import timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      term_hit,
  input  logic      out_sel,
  input  out_mode_e mode,
  output logic      out_q
);
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (term_hit && out_sel) begin
      unique case (mode)
        OUT_TOGGLE: out_d = ~out_q;
        OUT_LOW:    out_d = 1'b0;
        OUT_HIGH:   out_d = 1'b1;
        default:    out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              out_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              tmr_out
);
  localparam int NUM_CH = 2;
  localparam int NB     = CNT_W / 8;
  localparam logic [NUM_CH-1:0] OUT_MASK = 2'b10;  // channel 1 drives the pin

  logic [1:0]        rst_sync;
  logic              rst_i;
  logic [NUM_CH-1:0] ie_q, ie_d, en_q, en_d, flag_v, term_v;
  out_mode_e         oc_q, oc_d;
  logic              stat_rd, stat_wr;
  logic [CNT_W-1:0]  cnt_v [NUM_CH];
  logic [CNT_W-1:0]  rld_v [NUM_CH];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign stat_rd = rd_en && (addr == ADDR_W'(STAT_ADDR));
  assign stat_wr = wr_en && (addr == ADDR_W'(STAT_ADDR));

  always_comb begin
    ie_d = ie_q;
    oc_d = oc_q;
    en_d = en_q;
    if (stat_wr) begin
      ie_d = wdata[5:4];
      oc_d = out_mode_e'(wdata[3:2]);
      en_d = wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ie_q <= '0;
      oc_q <= OUT_KEEP;
      en_q <= '0;
    end else begin
      ie_q <= ie_d;
      oc_q <= oc_d;
      en_q <= en_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(
      .CNT_W (CNT_W),
      .ADDR_W(ADDR_W),
      .BASE  (ch_base(g, NB))
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_i),
      .tick    (tick),
      .count_en(en_q[g]),
      .stat_rd (stat_rd),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .cnt_q   (cnt_v[g]),
      .rld_q   (rld_v[g]),
      .flag_q  (flag_v[g]),
      .term_ev (term_v[g])
    );
  end

  tmr_outctl u_out (
    .clk     (clk),
    .rst_n   (rst_i),
    .term_hit(|(term_v & OUT_MASK)),
    .out_sel (out_sel),
    .mode    (oc_q),
    .out_q   (tmr_out)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(STAT_ADDR))
      rdata = {flag_v[1], flag_v[0], ie_q[1], ie_q[0], oc_q, en_q[1], en_q[0]};
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < NB; b++) begin
        if (addr == ADDR_W'(ch_base(c, NB) + b))      rdata = cnt_v[c][8*b +: 8];
        if (addr == ADDR_W'(ch_base(c, NB) + NB + b)) rdata = rld_v[c][8*b +: 8];
      end
    end
  end

  assign irq = |(flag_v & ie_q);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              out_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic              tmr_out,
  input logic              flag0,
  input logic              flag1,
  input logic [1:0]        en,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1
);
  localparam int NB = CNT_W / 8;

  logic ch0_cnt_addr, ch1_cnt_addr;
  assign ch0_cnt_addr = (int'(addr) >= 4) && (int'(addr) < 4 + NB);
  assign ch1_cnt_addr = (int'(addr) >= 4 + 2*NB) && (int'(addr) < 4 + 3*NB);

  p_irq_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0) |-> (irq == ((rdata[7] && rdata[5]) || (rdata[6] && rdata[4]))));

  p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en[1] && cnt1 == CNT_W'(1) && !(wr_en && ch1_cnt_addr)) |=> flag1);

  p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag0) |-> $past(rd_en && ch0_cnt_addr));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && !(wr_en && ch0_cnt_addr)) |=> $stable(cnt0));

  p_pin_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_sel |=> $stable(tmr_out));
endmodule

bind dual_reload_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_i),
  .tick   (tick),
  .out_sel(out_sel),
  .addr   (addr),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .rdata  (rdata),
  .irq    (irq),
  .tmr_out(tmr_out),
  .flag0  (flag_v[0]),
  .flag1  (flag_v[1]),
  .en     (en_q),
  .cnt0   (cnt_v[0]),
  .cnt1   (cnt_v[1])
);

// File: tb/tb_dual_reload_timer.sv
`timescale 1ns/1ps
module tb_dual_reload_timer;
  logic       clk, rst_n, tick, out_sel, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq, tmr_out;

  int checks = 0, errors = 0;
  bit run = 0, done = 0;

  dual_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .out_sel(out_sel), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .irq(irq), .tmr_out(tmr_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [15:0] m_cnt [2];
  logic [15:0] m_rld [2];
  bit m_flag [2];
  bit m_arm [2];
  bit m_ie [2];
  bit m_en [2];
  bit [1:0] m_oc;
  bit m_out;

  always @(posedge clk) begin
    bit sr, crd, cwr;
    bit ev [2];
    int base;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_flag[c] = 0; m_arm[c] = 0;
        m_ie[c] = 0; m_en[c] = 0;
      end
      m_oc = 0; m_out = 0;
    end else begin
      sr = rd_en && addr == 0;
      for (int c = 0; c < 2; c++) begin
        base = 4 + 4*c;
        ev[c] = 0;
        crd = rd_en && (addr == base || addr == base + 1);
        cwr = wr_en && (addr == base || addr == base + 1);
        if (cwr) begin
          if (addr == base) m_cnt[c][7:0] = wdata;
          else              m_cnt[c][15:8] = wdata;
        end else if (tick && m_en[c]) begin
          if (m_cnt[c] == 0) m_cnt[c] = m_rld[c];
          else begin
            m_cnt[c] = m_cnt[c] - 1;
            if (m_cnt[c] == 0) ev[c] = 1;
          end
        end
        if (wr_en && addr == base + 2) m_rld[c][7:0]  = wdata;
        if (wr_en && addr == base + 3) m_rld[c][15:8] = wdata;
        if (ev[c]) m_flag[c] = 1;
        else if (m_arm[c] && crd) m_flag[c] = 0;
        if (sr) m_arm[c] = 1;
        else if (crd) m_arm[c] = 0;
      end
      if (ev[1] && out_sel) begin
        case (m_oc)
          2'b01: m_out = !m_out;
          2'b10: m_out = 0;
          2'b11: m_out = 1;
          default: ;
        endcase
      end
      if (wr_en && addr == 0) {m_ie[1], m_ie[0], m_oc, m_en[1], m_en[0]} = wdata[5:0];
    end
  end

  function automatic logic [7:0] m_rdata(input logic [3:0] a);
    case (a)
      4'd0:  return {m_flag[1], m_flag[0], m_ie[1], m_ie[0], m_oc, m_en[1], m_en[0]};
      4'd4:  return m_cnt[0][7:0];
      4'd5:  return m_cnt[0][15:8];
      4'd6:  return m_rld[0][7:0];
      4'd7:  return m_rld[0][15:8];
      4'd8:  return m_cnt[1][7:0];
      4'd9:  return m_cnt[1][15:8];
      4'd10: return m_rld[1][7:0];
      4'd11: return m_rld[1][15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of registered outputs against the model
  always @(negedge clk) begin
    if (run) begin
      chk(16'(irq), 16'((m_flag[0] && m_ie[0]) || (m_flag[1] && m_ie[1])), "R3 irq vs model");
      chk(16'(tmr_out), 16'(m_out), "R5 tmr_out vs model");
    end
  end

  // drive one cycle of stimulus, called just after a falling edge
  task automatic step(input bit t, input bit w, input bit r, input logic [3:0] a,
                      input logic [7:0] d, input string tag);
    tick = t; wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) chk(16'(rdata), 16'(m_rdata(a)), tag);
    @(negedge clk);
  endtask

  task automatic idle();  step(0, 0, 0, 0, 8'h00, ""); endtask
  task automatic tk();    step(1, 0, 0, 0, 8'h00, ""); endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d); step(0, 1, 0, a, d, ""); endtask
  task automatic rd(input logic [3:0] a, input string tag); step(0, 0, 1, a, 8'h00, tag); endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; out_sel = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run = 1;

    // R8: reset state
    tick = 0; rd_en = 1; addr = 0; #1;
    chk(16'(rdata), 16'h00, "R8 status after reset");
    chk(16'({irq, tmr_out}), 16'h0, "R8 outputs after reset");
    @(negedge clk);
    rd(4, "R8 ch0 count after reset");
    rd(10, "R8 ch1 reload after reset");

    // R7: disabled channel holds and is writable
    wr(6, 8'h03); wr(7, 8'h00); wr(4, 8'h02); wr(5, 8'h00);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 4, 8'h00, "R7 count held while disabled");
    tick = 0; rd_en = 1; addr = 4; #1; chk(16'(rdata), 16'h02, "R7 held value"); @(negedge clk);
    rd(6, "R7 reload readback");

    // R1 R10: enable ch0 with interrupt
    wr(0, 8'h11);
    tk(); tk();
    chk(16'(irq), 16'h1, "R1 R3 flag raises irq at zero");
    idle(); idle();
    rd(4, "R10 no change without tick");
    chk(16'(irq), 16'h1, "R2 lone count read keeps flag");
    tick = 0; rd_en = 1; addr = 0; #1; chk(16'(rdata), 16'h51, "R4 status layout"); @(negedge clk);
    rd(4, "R2 clearing read");
    chk(16'(irq), 16'h0, "R2 flag cleared after sequence");
    tk();
    tick = 0; rd_en = 1; addr = 4; #1; chk(16'(rdata), 16'h03, "R9 reload after zero"); @(negedge clk);

    // R3: interrupt gated by enable
    wr(0, 8'h01);
    tk(); tk(); tk();
    chk(16'(irq), 16'h0, "R3 no irq while disabled");
    rd(0, "R1 flag set with ie off");

    // R11: set beats clear
    rd(0, "R2 arm"); rd(4, "R2 clear");
    tk(); tk(); tk();
    rd(0, "R11 arm");
    step(1, 0, 1, 4, 8'h00, "R11 read during terminal tick");
    tick = 0; rd_en = 1; addr = 0; #1; chk(16'(rdata[6]), 16'h1, "R11 flag kept"); @(negedge clk);
    wr(0, 8'h00);

    // R5 R6: output modes on channel 1
    out_sel = 1;
    wr(10, 8'h01); wr(11, 8'h00); wr(8, 8'h01); wr(9, 8'h00);
    wr(0, 8'h06);
    tk(); chk(16'(tmr_out), 16'h1, "R5 toggle to high");
    tk(); tk(); chk(16'(tmr_out), 16'h0, "R5 toggle to low");
    wr(0, 8'h0E);
    tk(); tk(); chk(16'(tmr_out), 16'h1, "R5 force high");
    wr(0, 8'h02);
    tk(); tk(); chk(16'(tmr_out), 16'h1, "R5 mode 00 unchanged");
    wr(0, 8'h0A);
    tk(); tk(); chk(16'(tmr_out), 16'h0, "R5 force low");
    out_sel = 0;
    wr(0, 8'h0E);
    tk(); tk(); chk(16'(tmr_out), 16'h0, "R6 pin ignores timer when deselected");
    out_sel = 1;

    // R3 R2 on channel 1
    wr(0, 8'h22);
    chk(16'(irq), 16'h1, "R3 ch1 flag with ie1");
    rd(0, "R2 ch1 arm"); rd(8, "R2 ch1 clear");
    chk(16'(irq), 16'h0, "R2 ch1 flag cleared");
    idle(); idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule